// File: doc/BRIEF.md
# Pipelined/SAR Digital Code Combiner

This block builds the final 12-bit output word of a hybrid converter. Two cascaded pipeline stages each deliver a 3-bit coarse code that carries half a bit of redundancy. A pair of successive-approximation sub-converters deliver the 8-bit fine result, and they take turns on alternate samples. Each source has its own valid strobe and reaches the block at a different time. The stage-2 code arrives one cycle after the stage-1 code, and the fine result arrives a few cycles after that.

The block delays both coarse codes through parameterised delay lines so that each one meets the fine result of its own sample. It picks the fine result from lane A or lane B using a parity bit that advances with every stage-1 sample. It then overlap-adds the three codes with weights 512, 128 and 1. Because the weights overlap, an offset in a coarse comparator is absorbed into the fine code. The sum is clipped to 12 bits and registered together with a valid flag.

Top module: `pscc_code_combiner`

## Requirements
- R1: During reset and after its release, `out_vld` and `out_code` are 0. They stay 0 until the first sample has crossed the stage-1 delay line.
- R2: A stage-1 code strobed on clock edge k is combined with the fine result presented on edge k+S1_DEPTH. A stage-2 code is combined with the fine result presented S2_DEPTH edges after it. With the defaults 3 and 2, the stage-2 code follows one edge after stage 1.
- R3: The result is registered on the edge that takes the fine result. `out_code` = d1*512 + d2*128 + fine, where d1 and d2 are the unsigned 3-bit coarse codes and fine is the unsigned 8-bit result.
- R4: Counting stage-1 strobes from 0 after reset, even samples take `sar_a_code`/`sar_a_vld` and odd samples take `sar_b_code`/`sar_b_vld`. The lane that is not selected has no effect on the output.
- R5: A sum above 4095, which is possible with the out-of-range coarse code 7, gives `out_code` = 4095.
- R6: `out_vld` is 1 only when the stage-1 valid, the matching stage-2 valid and the selected lane's valid are all present. Otherwise `out_vld` is 0 and `out_code` keeps its previous value.
- R7: The lane parity advances once for each stage-1 strobe, including samples that are dropped under R6. Cycles without a stage-1 strobe do not advance it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one sample per cycle |
| rst | input | 1 | Synchronous active-high reset |
| s1_vld | input | 1 | Stage-1 code valid |
| s1_code | input | 3 | Stage-1 coarse code |
| s2_vld | input | 1 | Stage-2 code valid |
| s2_code | input | 3 | Stage-2 coarse code |
| sar_a_vld | input | 1 | Lane A fine result valid |
| sar_a_code | input | 8 | Lane A fine result |
| sar_b_vld | input | 1 | Lane B fine result valid |
| sar_b_code | input | 8 | Lane B fine result |
| out_vld | output | 1 | Combined word valid |
| out_code | output | 12 | Combined, clipped output word |

## Verification
A wrong lane parity shows up at the first odd sample: the output carries the bitwise complement of the expected fine code, because the bench loads the idle lane with that complement. A delay line of the wrong depth pairs a coarse code with a neighbouring sample. This moves `out_code` by multiples of 128 or 512 within a cycle or two of reset. A parity that counts dropped or absent samples the wrong way only diverges after a gap, so the sweep mixes gaps and missing strobes to expose it within a few samples. The sweep covers every pair of coarse codes, and the clip path shows up as soon as d1 reaches 7.

// File: rtl/pscc_pkg.sv
package pscc_pkg;

  // Clip an unsigned sum into an OUT_W-bit code
  function automatic logic [31:0] clip_code(input logic [31:0] sum, input int unsigned out_w);
    logic [31:0] top;
    top = (32'd1 << out_w) - 32'd1;
    return (sum > top) ? top : sum;
  endfunction

endpackage

// File: rtl/pscc_delay.sv
module pscc_delay #(
  parameter int W     = 3,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_vld,
  input  logic [W-1:0] in_data,
  output logic         out_vld,
  output logic [W-1:0] out_data
);

  generate
    if (DEPTH == 0) begin : g_pass
      assign out_vld  = in_vld;
      assign out_data = in_data;
    end else begin : g_line
      // Data taps carry no reset so they can map to shift-register cells
      logic [W-1:0]     tap_q [DEPTH];
      logic [DEPTH-1:0] vld_q;

      always_ff @(posedge clk) begin
        tap_q[0] <= in_data;
        for (int i = 1; i < DEPTH; i++) tap_q[i] <= tap_q[i-1];
      end

      always_ff @(posedge clk) begin
        if (rst) vld_q <= '0;
        else if (DEPTH == 1) vld_q <= in_vld;
        else vld_q <= {vld_q[DEPTH-2:0], in_vld};
      end

      assign out_vld  = vld_q[DEPTH-1];
      assign out_data = tap_q[DEPTH-1];

      // R1: the valid bits are all cleared on the cycle after a reset
      a_r1_line_empty: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (vld_q == '0));
    end
  endgenerate

endmodule

// File: rtl/pscc_lane_sel.sv
module pscc_lane_sel #(
  parameter int SAR_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic             a_vld,
  input  logic [SAR_W-1:0] a_code,
  input  logic             b_vld,
  input  logic [SAR_W-1:0] b_code,
  output logic             sel_vld,
  output logic [SAR_W-1:0] sel_code,
  output logic             odd
);

  always_ff @(posedge clk) begin
    if (rst) odd <= 1'b0;
    else if (take) odd <= ~odd;
  end

  always_comb begin
    sel_vld  = odd ? b_vld  : a_vld;
    sel_code = odd ? b_code : a_code;
  end

  // R7: each sample moves the parity once
  a_r7_turn: assert property (@(posedge clk) disable iff (rst)
    take |=> (odd != $past(odd)));
  // R7: no sample, no movement
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    !take |=> $stable(odd));
  // R4: the first sample after reset uses lane A
  a_r4_start_even: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !odd);

endmodule

// File: rtl/pscc_merge.sv
module pscc_merge #(
  parameter int STAGE_W = 3,
  parameter int SAR_W   = 8,
  parameter int OUT_W   = SAR_W + 2 * (STAGE_W - 1)
) (
  input  logic [STAGE_W-1:0] d1,
  input  logic [STAGE_W-1:0] d2,
  input  logic [SAR_W-1:0]   fine,
  output logic [OUT_W-1:0]   word,
  output logic               over
);
  import pscc_pkg::*;

  localparam int S2_SH = SAR_W - 1;
  localparam int S1_SH = S2_SH + STAGE_W - 1;
  localparam int SUM_W = OUT_W + 2;

  logic [SUM_W-1:0] w1, w2, wf, sum;
  logic [31:0]      clipped;

  always_comb begin
    w1  = {{(SUM_W-STAGE_W){1'b0}}, d1} << S1_SH;
    w2  = {{(SUM_W-STAGE_W){1'b0}}, d2} << S2_SH;
    wf  = {{(SUM_W-SAR_W){1'b0}}, fine};
    sum = w1 + w2 + wf;
    over = (sum >> OUT_W) != '0;
    clipped = clip_code(32'(sum), OUT_W);
    word = clipped[OUT_W-1:0];
  end

endmodule

// File: rtl/pscc_code_combiner.sv
module pscc_code_combiner #(
  parameter int STAGE_W  = 3,
  parameter int SAR_W    = 8,
  parameter int S1_DEPTH = 3,
  parameter int S2_DEPTH = 2,
  parameter int OUT_W    = SAR_W + 2 * (STAGE_W - 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               s1_vld,
  input  logic [STAGE_W-1:0] s1_code,
  input  logic               s2_vld,
  input  logic [STAGE_W-1:0] s2_code,
  input  logic               sar_a_vld,
  input  logic [SAR_W-1:0]   sar_a_code,
  input  logic               sar_b_vld,
  input  logic [SAR_W-1:0]   sar_b_code,
  output logic               out_vld,
  output logic [OUT_W-1:0]   out_code
);

  logic               c1_vld, c2_vld, sel_vld, odd, commit, over;
  logic [STAGE_W-1:0] c1_code, c2_code;
  logic [SAR_W-1:0]   sel_code;
  logic [OUT_W-1:0]   word;

  pscc_delay #(.W(STAGE_W), .DEPTH(S1_DEPTH)) i_dly1 (
    .clk(clk), .rst(rst), .in_vld(s1_vld), .in_data(s1_code),
    .out_vld(c1_vld), .out_data(c1_code));

  pscc_delay #(.W(STAGE_W), .DEPTH(S2_DEPTH)) i_dly2 (
    .clk(clk), .rst(rst), .in_vld(s2_vld), .in_data(s2_code),
    .out_vld(c2_vld), .out_data(c2_code));

  pscc_lane_sel #(.SAR_W(SAR_W)) i_lane (
    .clk(clk), .rst(rst), .take(c1_vld),
    .a_vld(sar_a_vld), .a_code(sar_a_code),
    .b_vld(sar_b_vld), .b_code(sar_b_code),
    .sel_vld(sel_vld), .sel_code(sel_code), .odd(odd));

  pscc_merge #(.STAGE_W(STAGE_W), .SAR_W(SAR_W), .OUT_W(OUT_W)) i_merge (
    .d1(c1_code), .d2(c2_code), .fine(sel_code), .word(word), .over(over));

  assign commit = c1_vld & c2_vld & sel_vld;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld  <= 1'b0;
      out_code <= '0;
    end else begin
      out_vld <= commit;
      if (commit) out_code <= word;
    end
  end

  // R1: clean outputs right after reset
  a_r1_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_vld && out_code == '0));
  // R6: a dropped sample leaves the code untouched
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    (!out_vld && !$past(rst)) |-> $stable(out_code));
  // R6: no output without the selected lane's strobe
  a_r6_lane_needed: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> $past(sel_vld && c1_vld && c2_vld));
  // R5: an oversized sum lands on the ceiling
  a_r5_clip: assert property (@(posedge clk) disable iff (rst)
    (commit && over) |=> (out_vld && (&out_code)));

endmodule

// File: tb/test_pscc_code_combiner.sv
module test_pscc_code_combiner;
  localparam int CLK_PERIOD = 10;
  localparam int N = 256;
  localparam int NA = 192;

  logic       clk = 1'b0, rst = 1'b1;
  logic       s1_vld = 0, s2_vld = 0, sar_a_vld = 0, sar_b_vld = 0;
  logic [2:0] s1_code = 0, s2_code = 0;
  logic [7:0] sar_a_code = 0, sar_b_code = 0;
  logic       out_vld;
  logic [11:0] out_code;

  pscc_code_combiner i_pscc_code_combiner (
    .clk(clk), .rst(rst), .s1_vld(s1_vld), .s1_code(s1_code),
    .s2_vld(s2_vld), .s2_code(s2_code),
    .sar_a_vld(sar_a_vld), .sar_a_code(sar_a_code),
    .sar_b_vld(sar_b_vld), .sar_b_code(sar_b_code),
    .out_vld(out_vld), .out_code(out_code));

  always #(CLK_PERIOD/2) clk = ~clk;

  bit s1_on[N], s2_on[N], fine_on[N], lane[N];
  int d1[N], d2[N], fv[N];
  int n_chk = 0, n_bad = 0, exp_code = 0;
  bit done = 0;

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(int c);
    int j;
    s1_vld = 0; s2_vld = 0; sar_a_vld = 0; sar_b_vld = 0;
    if (c < N) begin
      s1_vld = s1_on[c]; s1_code = 3'(d1[c]);
    end
    j = c - 1;
    if (j >= 0 && j < N) begin
      s2_vld = s1_on[j] && s2_on[j]; s2_code = 3'(d2[j]);
    end
    j = c - 3;
    if (j >= 0 && j < N) begin
      if (!lane[j]) begin
        sar_a_vld = s1_on[j] && fine_on[j]; sar_a_code = 8'(fv[j]);
        sar_b_vld = 1'b1; sar_b_code = ~8'(fv[j]);
      end else begin
        sar_b_vld = s1_on[j] && fine_on[j]; sar_b_code = 8'(fv[j]);
        sar_a_vld = 1'b1; sar_a_code = ~8'(fv[j]);
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int par;
    par = 0;
    for (int k = 0; k < N; k++) begin
      if (k < NA) begin
        int p, v;
        p = k % 64; v = k / 64;
        d1[k] = p / 8; d2[k] = p % 8;
        fv[k] = (v == 0) ? 0 : (v == 1) ? 255 : ((p * 37 + 13) & 255);
        s1_on[k] = 1; s2_on[k] = 1; fine_on[k] = 1;
      end else begin
        d1[k] = (k * 3) % 8; d2[k] = (k * 5) % 8; fv[k] = (k * 29) & 255;
        s1_on[k] = (k % 5) != 0; s2_on[k] = (k % 7) != 3; fine_on[k] = (k % 6) != 4;
      end
      lane[k] = par[0];
      if (s1_on[k]) par = par ^ 1;
    end

    repeat (3) @(negedge clk);
    check("R1", int'(out_vld), 0);
    check("R1", int'(out_code), 0);
    rst = 1'b0;

    for (int c = 0; c < N + 3; c++) begin
      int j;
      drive(c);
      @(posedge clk);
      @(negedge clk);
      j = c - 3;
      if (j < 0) begin
        check("R1", int'(out_vld), 0);
        check("R1", int'(out_code), 0);
      end else begin
        int sum, ev;
        string tag;
        sum = d1[j] * 512 + d2[j] * 128 + fv[j];
        ev = (s1_on[j] && s2_on[j] && fine_on[j]) ? 1 : 0;
        if (ev) exp_code = (sum > 4095) ? 4095 : sum;
        if (j < NA) tag = (sum > 4095) ? "R5" : (lane[j] ? "R4" : "R2/R3");
        else if (!s1_on[j] || !s2_on[j] || !fine_on[j]) tag = "R6";
        else tag = "R7";
        check(tag, int'(out_vld), ev);
        check(tag, int'(out_code), exp_code);
      end
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule